// File: doc/BRIEF.md
# Glitch-Free Synchronized Clock Stop Gate

This block sits on one group of clock outputs and decides, cycle by cycle, whether the free-running source clock is passed through or held low. Two things can close the gate: an active-low stop request that may arrive at any time with no relation to the source clock, and an enable bit written by software. Both pass through a two-flop synchronizer clocked by the source clock before any decision is made.

The gate opens and closes only while the source clock is low. A stopped output therefore rests at 0, and the first pulse after a restart is a full high phase. The stop and restart delays are set by parameters, and so is the minimum number of pulses that must follow a restart before another stop is accepted. One design can then be built once for a fast processor clock group and once for a slower bus clock group. A stop request that arrives during that minimum run is remembered and carried out once the run is complete.

Top module: `clk_stop_gate`

## Requirements
- R1: After reset is released the gate is open, the minimum run already counts as met, and the gated output follows the source clock on every cycle.
- R2: If the stop request (low) is present before source rising edge k, the last gated high pulse starts at edge k+STOP_LAT and there is no pulse from edge k+STOP_LAT+1 on. The request passes through a synchronizer of depth 2, and STOP_LAT must be at least 2.
- R3: If the stop request is released before rising edge k while the output is stopped, the first gated pulse starts at edge k+START_LAT+1. START_LAT must be at least 2.
- R4: While stopped, the gated output stays at 0 through both phases of the source clock.
- R5: Every gated pulse starts at a source rising edge and stays high until the next source falling edge, with no shortened pulse at a stop or a restart.
- R6: Driving the software enable low stops the output with the same latency as the stop request, and driving it high again restarts the output with the restart latency, provided no stop is requested.
- R7: If a stop is requested at the falling edge right after the first pulse following a restart, exactly MIN_RUN + STOP_LAT - 2 pulses appear before the output stops.
- R8: A stop request that is removed again before the minimum run is complete is still carried out once the run completes. The output then restarts with START_LAT - 1 missing pulses.
- R9: Stopping one instance leaves another instance on the same source clock running on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Free-running source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stopReqN | input | 1 | Asynchronous stop request, active low |
| swEnable | input | 1 | Software output enable, 0 forces the output low |
| gatedClk | output | 1 | Gated clock output |

## Verification
The bench builds two instances on one source clock. The first uses latencies of 3/3 and a minimum run of 100 pulses, the second uses 2/2 and a minimum run of 10. With both, the case where the latency is extra wait cycles beyond the synchronizer is covered, and so is the case where it is the synchronizer alone. The short minimum run keeps the deferred-stop path quick to reach. The long one shows that the exact pulse count grows by the extra stop wait. Because the two instances share the source clock, stopping one while watching the other is a direct check that groups do not affect each other.

// File: rtl/clk_gate_pkg.sv
`timescale 1ns/1ps
package clk_gate_pkg;

  // strobes from the control to the gate datapath
  typedef struct packed {
    logic openStb;
    logic closeStb;
  } gateStrobe_t;

  typedef enum logic [1:0] {
    ST_RUN        = 2'd0,
    ST_STOP_WAIT  = 2'd1,
    ST_STOPPED    = 2'd2,
    ST_START_WAIT = 2'd3
  } gateState_t;

endpackage

// File: rtl/clk_gate_sync.sv
`timescale 1ns/1ps
module clk_gate_sync #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned DEPTH = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  // one flop chain per input bit
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain <= {DEPTH{RESET_VAL[b]}};
      end else begin
        chain <= {chain[DEPTH-2:0], asyncIn[b]};
      end
    end

    assign syncOut[b] = chain[DEPTH-1];
  end

endmodule

// File: rtl/clk_gate_ctrl.sv
`timescale 1ns/1ps
module clk_gate_ctrl
  import clk_gate_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = 2,
  parameter int unsigned STOP_LAT   = 3,
  parameter int unsigned START_LAT  = 3,
  parameter int unsigned MIN_RUN    = 100
) (
  input  logic        srcClk,
  input  logic        rstN,
  input  logic        stopWant,
  input  logic        armState,
  output gateStrobe_t strobe
);

  // cycles spent after the synchronizer before acting
  localparam int unsigned STOP_HOLD  = STOP_LAT - SYNC_DEPTH;
  localparam int unsigned START_HOLD = START_LAT - SYNC_DEPTH;
  localparam int unsigned HOLD_MAX   = (STOP_HOLD > START_HOLD) ? STOP_HOLD : START_HOLD;
  localparam int unsigned DLY_W      = $clog2(HOLD_MAX + 2);
  localparam int unsigned RUN_W      = $clog2(MIN_RUN + 1);
  localparam logic [DLY_W-1:0] STOP_HOLD_V  = DLY_W'(STOP_HOLD);
  localparam logic [DLY_W-1:0] START_HOLD_V = DLY_W'(START_HOLD);
  localparam logic [RUN_W-1:0] RUN_LIM      = RUN_W'(MIN_RUN - 1);

  gateState_t       state, stateNext;
  logic [DLY_W-1:0] dly, dlyNext;
  logic [RUN_W-1:0] runCnt, runNext;
  logic             pendStop, pendNext;
  logic             runReady;
  logic             stopDue;

  assign runReady = (runCnt == RUN_LIM);
  assign stopDue  = stopWant | pendStop;

  always_comb begin
    stateNext = state;
    dlyNext   = dly;
    pendNext  = pendStop;
    strobe    = '0;
    case (state)
      ST_RUN: begin
        if (stopDue && runReady) begin
          pendNext = 1'b0;
          if (STOP_HOLD == 0) begin
            strobe.closeStb = 1'b1;
            stateNext       = ST_STOPPED;
          end else begin
            stateNext = ST_STOP_WAIT;
            dlyNext   = DLY_W'(1);
          end
        end else begin
          pendNext = stopDue;
        end
      end
      ST_STOP_WAIT: begin
        if (dly == STOP_HOLD_V) begin
          strobe.closeStb = 1'b1;
          stateNext       = ST_STOPPED;
        end else begin
          dlyNext = dly + DLY_W'(1);
        end
      end
      ST_STOPPED: begin
        if (!stopWant) begin
          if (START_HOLD == 0) begin
            strobe.openStb = 1'b1;
            stateNext      = ST_RUN;
          end else begin
            stateNext = ST_START_WAIT;
            dlyNext   = DLY_W'(1);
          end
        end
      end
      ST_START_WAIT: begin
        if (stopWant) begin
          stateNext = ST_STOPPED;
        end else if (dly == START_HOLD_V) begin
          strobe.openStb = 1'b1;
          stateNext      = ST_RUN;
        end else begin
          dlyNext = dly + DLY_W'(1);
        end
      end
      default: stateNext = ST_RUN;
    endcase

    if (strobe.openStb) begin
      runNext = '0;
    end else if (state == ST_RUN && !runReady) begin
      runNext = runCnt + RUN_W'(1);
    end else begin
      runNext = runCnt;
    end
  end

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_RUN;
      dly      <= '0;
      runCnt   <= RUN_LIM;
      pendStop <= 1'b0;
    end else begin
      state    <= stateNext;
      dly      <= dlyNext;
      runCnt   <= runNext;
      pendStop <= pendNext;
    end
  end

  // R4
  stopped_low_chk: assert property (@(posedge srcClk) disable iff (!rstN)
    (state == ST_STOPPED) |-> !armState);

  // R3
  reopen_release_chk: assert property (@(posedge srcClk) disable iff (!rstN)
    $rose(armState) |-> !$past(stopWant));

  // R5
  strobe_excl_chk: assert property (@(posedge srcClk) disable iff (!rstN)
    !(strobe.openStb && strobe.closeStb));

endmodule

// File: rtl/clk_gate_dp.sv
`timescale 1ns/1ps
module clk_gate_dp
  import clk_gate_pkg::*;
#(
  parameter int unsigned MIN_RUN = 100
) (
  input  logic        srcClk,
  input  logic        rstN,
  input  gateStrobe_t strobe,
  output logic        armState,
  output logic        gatedClk
);

  localparam int unsigned RUN_W = $clog2(MIN_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(MIN_RUN - 1);

  logic armReg;
  logic gateLatch;

  // arm register follows the control strobes on the rising edge
  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      armReg <= 1'b1;
    end else if (strobe.closeStb) begin
      armReg <= 1'b0;
    end else if (strobe.openStb) begin
      armReg <= 1'b1;
    end
  end

  // the gate itself only moves while the source clock is low
  always_ff @(negedge srcClk or negedge rstN) begin
    if (!rstN) begin
      gateLatch <= 1'b1;
    end else begin
      gateLatch <= armReg;
    end
  end

  assign gatedClk = srcClk & gateLatch;
  assign armState = armReg;

  // independent count of rising edges since the gate was last opened
  logic [RUN_W-1:0] sinceOpen;
  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      sinceOpen <= RUN_LIM;
    end else if (strobe.openStb) begin
      sinceOpen <= '0;
    end else if (sinceOpen != RUN_LIM) begin
      sinceOpen <= sinceOpen + RUN_W'(1);
    end
  end

  // R7
  min_run_chk: assert property (@(posedge srcClk) disable iff (!rstN)
    strobe.closeStb |-> (sinceOpen == RUN_LIM));

endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate
  import clk_gate_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = 2,
  parameter int unsigned STOP_LAT   = 3,
  parameter int unsigned START_LAT  = 3,
  parameter int unsigned MIN_RUN    = 100
) (
  input  logic srcClk,
  input  logic rstN,
  input  logic stopReqN,
  input  logic swEnable,
  output logic gatedClk
);

  logic [1:0]  syncBits;
  logic        stopWant;
  logic        armState;
  gateStrobe_t strobe;

  // bit 1: software enable, bit 0: stop request (both active low for stopping)
  clk_gate_sync #(
    .WIDTH    (2),
    .DEPTH    (SYNC_DEPTH),
    .RESET_VAL(2'b11)
  ) u_sync (
    .clk    (srcClk),
    .rstN   (rstN),
    .asyncIn({swEnable, stopReqN}),
    .syncOut(syncBits)
  );

  assign stopWant = ~syncBits[0] | ~syncBits[1];

  clk_gate_ctrl #(
    .SYNC_DEPTH(SYNC_DEPTH),
    .STOP_LAT  (STOP_LAT),
    .START_LAT (START_LAT),
    .MIN_RUN   (MIN_RUN)
  ) u_ctrl (
    .srcClk  (srcClk),
    .rstN    (rstN),
    .stopWant(stopWant),
    .armState(armState),
    .strobe  (strobe)
  );

  clk_gate_dp #(
    .MIN_RUN(MIN_RUN)
  ) u_dp (
    .srcClk  (srcClk),
    .rstN    (rstN),
    .strobe  (strobe),
    .armState(armState),
    .gatedClk(gatedClk)
  );

endmodule

// File: tb/clk_stop_gate_tb.sv
`timescale 1ns/1ps
module clk_stop_gate_tb;

  localparam int A_STOP = 3, A_START = 3, A_RUN = 100;
  localparam int B_STOP = 2, B_START = 2, B_RUN = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopA = 1'b1, enA = 1'b1, gA;
  logic stopB = 1'b1, enB = 1'b1, gB;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always #10 clk = ~clk;

  clk_stop_gate #(.SYNC_DEPTH(2), .STOP_LAT(A_STOP), .START_LAT(A_START), .MIN_RUN(A_RUN)) u_dut (
    .srcClk(clk), .rstN(rstN), .stopReqN(stopA), .swEnable(enA), .gatedClk(gA));

  clk_stop_gate #(.SYNC_DEPTH(2), .STOP_LAT(B_STOP), .START_LAT(B_START), .MIN_RUN(B_RUN)) u_dut_pci (
    .srcClk(clk), .rstN(rstN), .stopReqN(stopB), .swEnable(enB), .gatedClk(gB));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic gOf(input int sel);
    return (sel == 0) ? gA : gB;
  endfunction

  function automatic logic gOther(input int sel);
    return (sel == 0) ? gB : gA;
  endfunction

  task automatic drive(input int sel, input bit useSw, input logic v);
    if (sel == 0) begin
      if (useSw) enA = v; else stopA = v;
    end else begin
      if (useSw) enB = v; else stopB = v;
    end
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // R1: output follows the source clock after reset
  task automatic t_reset();
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #5;
      check(gA === 1'b1, "R1 dut A high phase", gA, 1);
      check(gB === 1'b1, "R1 dut B high phase", gB, 1);
      #10;
      check(gA === 1'b0, "R1 dut A low phase", gA, 0);
    end
  endtask

  // R2/R6 stop latency, R4 rest low, R9 other instance undisturbed
  task automatic t_stop(input int sel, input bit useSw, input int lat);
    @(negedge clk);
    drive(sel, useSw, 1'b0);
    for (int i = 0; i <= lat + 3; i++) begin
      logic a;
      logic b;
      @(posedge clk); #1 a = gOf(sel); #8 b = gOf(sel);
      check(a === (i <= lat), useSw ? "R6 stop by enable" : "R2 stop latency", a, (i <= lat));
      if (i <= lat) check(b === 1'b1, "R5 full pulse before stop", b, 1);
    end
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #5;
      check(gOf(sel) === 1'b0, "R4 stopped high phase", gOf(sel), 0);
      check(gOther(sel) === 1'b1, "R9 other group runs", gOther(sel), 1);
      #10;
      check(gOf(sel) === 1'b0, "R4 stopped low phase", gOf(sel), 0);
    end
  endtask

  // R3/R6 restart latency and full first pulse
  task automatic t_start(input int sel, input bit useSw, input int lat);
    @(negedge clk);
    drive(sel, useSw, 1'b1);
    for (int i = 0; i <= lat + 3; i++) begin
      logic a;
      logic b;
      @(posedge clk); #1 a = gOf(sel); #8 b = gOf(sel);
      check(a === (i >= lat + 1), useSw ? "R6 restart by enable" : "R3 restart latency", a, (i >= lat + 1));
      if (i >= lat + 1) check(b === 1'b1, "R5 full pulse after restart", b, 1);
    end
  endtask

  // R7 minimum run, R8 deferred stop (called while stopped)
  task automatic t_min_run(input int sel, input int minRun, input int sLat, input int rLat, input bit shortReq);
    int cnt = 0;
    int gap = 0;
    bit seen = 0;
    @(negedge clk);
    drive(sel, 0, 1'b1);
    for (int i = 0; i < 20 && !seen; i++) begin
      @(posedge clk); #5;
      if (gOf(sel) === 1'b1) seen = 1;
    end
    check(seen, shortReq ? "R8 restart seen" : "R7 restart seen", seen, 1);
    @(negedge clk);
    drive(sel, 0, 1'b0);
    cnt = 1;
    for (int i = 1; i < 300; i++) begin
      @(posedge clk); #5;
      if (gOf(sel) !== 1'b1) break;
      cnt++;
      if (shortReq && i == 3) begin
        @(negedge clk);
        drive(sel, 0, 1'b1);
      end
    end
    check(cnt == minRun + sLat - 2, shortReq ? "R8 deferred stop pulses" : "R7 minimum run pulses",
          cnt, minRun + sLat - 2);
    if (shortReq) begin
      gap = 1;
      for (int i = 0; i < 20; i++) begin
        @(posedge clk); #5;
        if (gOf(sel) === 1'b1) break;
        gap++;
      end
      check(gap == rLat - 1, "R8 restart gap", gap, rLat - 1);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    waitEdges(A_RUN + 5);
    t_stop(0, 0, A_STOP);
    t_start(0, 0, A_START);
    waitEdges(A_RUN + 5);
    t_stop(0, 1, A_STOP);
    t_start(0, 1, A_START);
    waitEdges(B_RUN + 5);
    t_stop(1, 0, B_STOP);
    t_start(1, 0, B_START);
    waitEdges(B_RUN + 5);
    t_stop(1, 1, B_STOP);
    t_start(1, 1, B_START);
    waitEdges(A_RUN + 5);
    t_stop(0, 0, A_STOP);
    t_min_run(0, A_RUN, A_STOP, A_START, 0);
    t_min_run(0, A_RUN, A_STOP, A_START, 1);
    waitEdges(B_RUN + 5);
    t_stop(1, 0, B_STOP);
    t_min_run(1, B_RUN, B_STOP, B_START, 0);
    t_min_run(1, B_RUN, B_STOP, B_START, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule